// File: doc/BRIEF.md
# Dual-Half SECDED Read Checker with Injection Test Path

This block sits on the read path of a flash array. Every 128-bit read word is split into two 64-bit halves, and each half goes to its own single-error-correct, double-error-detect unit. Each unit has 8 check bits. The check bits protect the 64 data bits and also the 19-bit address of the 64-bit word. A read from the wrong location therefore shows up as an error, even when the data bits themselves are intact. Each unit corrects a single flipped data bit and reports a single flipped check bit. Every other nonzero syndrome is marked uncorrectable.

Each read is decoded and the result is registered. The block then drives the corrected word, a sticky status word, a one-cycle correctable-error interrupt pulse and a one-cycle non-maskable error pulse. The interrupt pulse is gated by a counter of correctable errors and a programmable threshold.

For a periodic self-check, software can switch one of the two units onto a set of test registers. These registers hold 64 data bits, 8 check bits and 19 address bits. The chosen unit then decodes those values on every clock cycle, and the flash read path is shut off. Writing deliberately corrupted values shows whether the checker catches each class of fault. Writing clean values shows that it raises no false alarm.

Top module: `flash_secded_check`

## Requirements
- R1: Code definition. The payload is 83 bits: address bit k sits at payload index 64+k, and data bit i sits at payload index i. Each payload index gets an 8-bit column:
  - Indices 0..55 take the bytes of weight 3, in ascending numeric order.
  - Indices 56..82 take the first 27 bytes of weight 5, in ascending numeric order.
  - Check bit r is the XOR of the payload bits whose column has bit r set.
  - A clean read returns its data unchanged and raises no flag, interrupt or NMI.
- R2: If the syndrome equals the column of data bit i, that bit is inverted in the output, the correctable flag (status bit 0) is set and the position field (status bits 14:8) holds i.
- R3: If the syndrome has exactly one bit set, at bit r, the data passes unchanged, the correctable flag is set and the position field holds 64+r.
- R4: Every other nonzero syndrome sets the uncorrectable flag (status bit 1), raises nmi_req and passes the data uncorrected. This covers double-bit errors and single address-bit mismatches.
- R5: Lower unit:
  - It decodes rd_data[63:0] with rd_ecc[7:0] and address {rd_waddr,0}.
  - When it has a correctable error, it is recorded in preference to the upper unit, and status bit 2 reads 0.
  
  Upper unit:
  - It decodes rd_data[127:64] with rd_ecc[15:8] and address {rd_waddr,1}.
  - When only the upper unit has a correctable error, status bit 2 reads 1.
- R6: Register write map:
  - Offset 0 is control: bit 0 enables test mode, and bit 1 selects the upper unit.
  - Offsets 1 and 2 hold the low and high 32 test data bits.
  - Offset 3 holds the test check byte, and offset 4 holds the test address.
  - Offset 5 holds the threshold.
  - Offset 6 is a clear command: bit 0 clears the flags, and bit 1 clears the counter.
- R7: While test mode is on:
  - The selected unit decodes the test registers in every cycle.
  - Its corrected output appears on test_out_hi/test_out_lo.
  - rd_valid is ignored, so out_valid stays 0.
  - Error pulses repeat every cycle and stop once test mode is cleared.
- R8: The counter (status bits 16 and up) adds one in each decoded cycle that has any correctable error, and it saturates at its maximum. sbe_irq pulses when the updated count exceeds the threshold, so a threshold of 0 fires on every correctable error.
- R9: The flags, the position and the unit bit stay set until a clear is written. If an error arrives in the same cycle as a clear, the error is recorded.
- R10: All outputs change one clock edge after the read or test cycle that produced them. Without a read or test mode, no pulses are produced.
- R11: After reset, out_valid, the status word, both pulses and the test outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Flash read word present |
| rd_waddr | input | 18 | Address of the 128-bit word |
| rd_data | input | 128 | Raw read data |
| rd_ecc | input | 16 | Check bytes, upper unit in bits 15:8 |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| out_valid | output | 1 | Corrected word valid |
| out_data | output | 128 | Corrected word |
| test_out_hi | output | 32 | Unit under test, output bits 63:32 |
| test_out_lo | output | 32 | Unit under test, output bits 31:0 |
| err_status | output | 32 | Flags, unit, position, counter |
| sbe_irq | output | 1 | Correctable-error interrupt pulse |
| nmi_req | output | 1 | Uncorrectable-error pulse |

## Verification
The bench goes after the places where the syndrome classification can go wrong:
- A single address-bit mismatch must be reported as uncorrectable. A decoder that searched the address columns as if they were data would raise a correctable error instead.
- A flipped check bit must leave the data untouched and report a position of 64 or above. A decoder that mapped check-bit errors onto data positions would corrupt clean data.

It also covers the counter and the flag registers:
- The threshold is run at 2 across three consecutive errors, so a comparison off by one shows up as an early or a missing pulse.
- A long run in test mode drives the counter into saturation, where a wrapping counter would drop back to zero.
- A clear is written in the same cycle as a new error, so a design that let the clear win would lose that error.

// File: rtl/secded_pkg.sv
// Shared definitions for the SECDED read checker.
// Assumes a fixed 64-bit data half, 8 check bits and a 19-bit word address.
// The column table is computed here: weight-3 bytes first, then weight-5 bytes,
// each group in ascending numeric order.
package secded_pkg;
    localparam int DW     = 64;
    localparam int AW     = 19;
    localparam int CW     = 8;
    localparam int PW     = DW + AW;
    localparam int POS_W  = 7;
    localparam int NUNIT  = 2;
    localparam int RD_W   = NUNIT * DW;
    localparam int RCW    = NUNIT * CW;
    localparam int REG_W  = 32;
    localparam int OFS_W  = 3;

    // Register offsets written through the write port.
    typedef enum logic [OFS_W-1:0] {
        OFS_CTRL  = 3'd0,
        OFS_TDLO  = 3'd1,
        OFS_TDHI  = 3'd2,
        OFS_TCHK  = 3'd3,
        OFS_TADR  = 3'd4,
        OFS_THR   = 3'd5,
        OFS_CLR   = 3'd6,
        OFS_NONE  = 3'd7
    } reg_ofs_e;

    // Decode result of one unit.
    typedef struct packed {
        logic [DW-1:0]    data;
        logic             sbe;
        logic             ue;
        logic [POS_W-1:0] pos;
    } dec_t;

    // Builds the flat column table, one CW-bit column per payload index.
    function automatic logic [PW*CW-1:0] build_cols();
        logic [PW*CW-1:0] cols;
        int n;
        cols = '0;
        n = 0;
        for (int w = 3; w <= 5; w += 2) begin
            for (int v = 1; v < 256; v++) begin
                if ($countones(v[7:0]) == w && n < PW) begin
                    cols[n*CW +: CW] = v[7:0];
                    n++;
                end
            end
        end
        return cols;
    endfunction

    localparam logic [PW*CW-1:0] HCOLS = build_cols();
endpackage

// File: rtl/secded_unit.sv
// One SECDED unit: computes the syndrome over data, address and check bits,
// then classifies and corrects it.
// Purely combinational; the caller registers the results.
// Assumes secded_pkg::HCOLS holds distinct odd-weight columns.
module secded_unit
    import secded_pkg::*;
(
    input  logic [DW-1:0] data_i,
    input  logic [CW-1:0] chk_i,
    input  logic [AW-1:0] addr_i,
    output dec_t          res_o
);
    logic [PW-1:0]    payload;
    logic [CW-1:0]    syn;
    logic [DW-1:0]    flip;
    logic             data_hit;
    logic             chk_hit;
    logic [POS_W-1:0] pos;

    assign payload = {addr_i, data_i};

    // Syndrome: recomputed check bits XOR the received check bits.
    always_comb begin
        syn = chk_i;
        for (int j = 0; j < PW; j++) begin
            if (payload[j]) syn = syn ^ HCOLS[j*CW +: CW];
        end
    end

    // Match the syndrome against the data columns and the unit columns.
    always_comb begin
        flip     = '0;
        data_hit = 1'b0;
        pos      = '0;
        for (int i = 0; i < DW; i++) begin
            if (syn == HCOLS[i*CW +: CW]) begin
                flip[i]  = 1'b1;
                data_hit = 1'b1;
                pos      = POS_W'(i);
            end
        end
        chk_hit = ($countones(syn) == 1);
        if (chk_hit) begin
            for (int r = 0; r < CW; r++) begin
                if (syn[r]) pos = POS_W'(DW + r);
            end
        end
    end

    assign res_o.data = data_i ^ flip;
    assign res_o.sbe  = data_hit | chk_hit;
    assign res_o.ue   = (syn != '0) && !(data_hit || chk_hit);
    assign res_o.pos  = pos;
endmodule

// File: rtl/secded_csr.sv
// Register file for test mode, threshold and clear commands.
// Write-only, one register per cycle.
// The clear offset produces one-cycle pulses and holds no state.
module secded_csr
    import secded_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic             test_en_o,
    output logic             unit_sel_o,
    output logic [DW-1:0]    t_data_o,
    output logic [CW-1:0]    t_chk_o,
    output logic [AW-1:0]    t_addr_o,
    output logic [CNT_W-1:0] thresh_o,
    output logic             clr_flags_o,
    output logic             clr_cnt_o
);
    reg_ofs_e ofs;
    assign ofs = reg_ofs_e'(wr_addr);

    // Register update on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_en_o  <= 1'b0;
            unit_sel_o <= 1'b0;
            t_data_o   <= '0;
            t_chk_o    <= '0;
            t_addr_o   <= '0;
            thresh_o   <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_CTRL: begin
                    test_en_o  <= wr_data[0];
                    unit_sel_o <= wr_data[1];
                end
                OFS_TDLO: t_data_o[REG_W-1:0]  <= wr_data;
                OFS_TDHI: t_data_o[DW-1:REG_W] <= wr_data;
                OFS_TCHK: t_chk_o  <= wr_data[CW-1:0];
                OFS_TADR: t_addr_o <= wr_data[AW-1:0];
                OFS_THR:  thresh_o <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    assign clr_flags_o = wr_en && (ofs == OFS_CLR) && wr_data[0];
    assign clr_cnt_o   = wr_en && (ofs == OFS_CLR) && wr_data[1];
endmodule

// File: rtl/sbe_threshold_ctr.sv
// Saturating counter of correctable-error cycles, with threshold-gated interrupt.
// A clear takes effect before the increment of the same cycle.
// irq_o is a registered one-cycle pulse.
module sbe_threshold_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] nxt;

    // Next count: optional clear, then a saturating increment.
    always_comb begin
        base = clr_i ? '0 : cnt_o;
        nxt  = base;
        if (evt_i && base != CMAX) nxt = base + CNT_W'(1);
    end

    // Count and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
            irq_o <= 1'b0;
        end else begin
            cnt_o <= nxt;
            irq_o <= evt_i && (nxt > thresh_i);
        end
    end

    assert_cnt_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CMAX && evt_i && !clr_i) |=> (cnt_o == CMAX));
    assert_thresh_zero_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && thresh_i == '0) |=> irq_o);
endmodule

// File: rtl/flash_secded_check.sv
// Top of the flash read checker: two SECDED units over the halves of a 128-bit read.
// A test mux feeds the register values into the selected unit.
// Also holds the sticky status, the correctable-error counter and the error pulses.
// Assumes CNT_W <= 16 so the counter fits in status bits 31:16.
module flash_secded_check
    import secded_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_valid,
    input  logic [AW-2:0]      rd_waddr,
    input  logic [RD_W-1:0]    rd_data,
    input  logic [RCW-1:0]     rd_ecc,
    input  logic               reg_wr_en,
    input  logic [OFS_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic               out_valid,
    output logic [RD_W-1:0]    out_data,
    output logic [REG_W-1:0]   test_out_hi,
    output logic [REG_W-1:0]   test_out_lo,
    output logic [REG_W-1:0]   err_status,
    output logic               sbe_irq,
    output logic               nmi_req
);
    localparam int CNT_LSB = 16;

    logic             test_en;
    logic             unit_sel;
    logic [DW-1:0]    t_data;
    logic [CW-1:0]    t_chk;
    logic [AW-1:0]    t_addr;
    logic [CNT_W-1:0] thresh;
    logic             clr_flags;
    logic             clr_cnt;

    secded_csr #(.CNT_W(CNT_W)) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .wr_addr     (reg_addr),
        .wr_data     (reg_wdata),
        .test_en_o   (test_en),
        .unit_sel_o  (unit_sel),
        .t_data_o    (t_data),
        .t_chk_o     (t_chk),
        .t_addr_o    (t_addr),
        .thresh_o    (thresh),
        .clr_flags_o (clr_flags),
        .clr_cnt_o   (clr_cnt)
    );

    dec_t             res     [NUNIT];
    logic [NUNIT-1:0] sbe_evt;
    logic [NUNIT-1:0] ue_evt;

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        logic          is_tgt;
        logic          eval;
        logic [DW-1:0] d_in;
        logic [CW-1:0] c_in;
        logic [AW-1:0] a_in;

        // Input mux: test registers for the selected unit, flash otherwise.
        assign is_tgt = test_en && (unit_sel == 1'(u));
        assign eval   = test_en ? is_tgt : rd_valid;
        assign d_in   = is_tgt ? t_data : rd_data[u*DW +: DW];
        assign c_in   = is_tgt ? t_chk  : rd_ecc[u*CW +: CW];
        assign a_in   = is_tgt ? t_addr : {rd_waddr, 1'(u)};

        secded_unit u_dec (
            .data_i (d_in),
            .chk_i  (c_in),
            .addr_i (a_in),
            .res_o  (res[u])
        );

        assign sbe_evt[u] = eval && res[u].sbe;
        assign ue_evt[u]  = eval && res[u].ue;
    end

    logic             any_sbe;
    logic             any_ue;
    logic [CNT_W-1:0] cnt;

    assign any_sbe = |sbe_evt;
    assign any_ue  = |ue_evt;

    sbe_threshold_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (any_sbe),
        .clr_i    (clr_cnt),
        .thresh_i (thresh),
        .cnt_o    (cnt),
        .irq_o    (sbe_irq)
    );

    // Corrected flash word register; the flash path is shut off in test mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= rd_valid && !test_en;
            if (rd_valid && !test_en) out_data <= {res[1].data, res[0].data};
        end
    end

    // Capture the output of the unit under test on every test cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_out_hi <= '0;
            test_out_lo <= '0;
        end else if (test_en) begin
            test_out_hi <= res[unit_sel].data[DW-1:REG_W];
            test_out_lo <= res[unit_sel].data[REG_W-1:0];
        end
    end

    logic             rec_unit;
    logic [POS_W-1:0] rec_pos;

    // Pick the unit to record: the lower unit wins when both have an error.
    always_comb begin
        rec_unit = 1'b0;
        rec_pos  = res[0].pos;
        if (!sbe_evt[0] && sbe_evt[1]) begin
            rec_unit = 1'b1;
            rec_pos  = res[1].pos;
        end
    end

    logic             sbe_flag;
    logic             ue_flag;
    logic             st_unit;
    logic [POS_W-1:0] st_pos;

    // Sticky flags; a new error in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sbe_flag <= 1'b0;
            ue_flag  <= 1'b0;
            st_unit  <= 1'b0;
            st_pos   <= '0;
            nmi_req  <= 1'b0;
        end else begin
            sbe_flag <= any_sbe | (sbe_flag & !clr_flags);
            ue_flag  <= any_ue  | (ue_flag  & !clr_flags);
            if (any_sbe) begin
                st_unit <= rec_unit;
                st_pos  <= rec_pos;
            end else if (clr_flags) begin
                st_unit <= 1'b0;
                st_pos  <= '0;
            end
            nmi_req <= any_ue;
        end
    end

    // Status word packing.
    always_comb begin
        err_status                  = '0;
        err_status[0]               = sbe_flag;
        err_status[1]               = ue_flag;
        err_status[2]               = st_unit;
        err_status[8 +: POS_W]      = st_pos;
        err_status[CNT_LSB +: CNT_W] = cnt;
    end

    assert_nmi_follows_ue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any_ue |=> nmi_req);
    assert_flash_blocked_in_test_R7: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |=> !out_valid);
    assert_sbe_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_flag && !clr_flags) |=> sbe_flag);
    assert_ue_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_flag && !clr_flags) |=> ue_flag);
    assert_irq_needs_sbe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_sbe |=> !sbe_irq);
endmodule

// File: tb/tb_flash_secded_check.sv
// Scoreboard bench: the driver task models each cycle and queues the expected outputs;
// the monitor pops one item per cycle and compares it.
module tb_flash_secded_check;
    localparam int TCNT = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         rd_valid;
    logic [17:0]  rd_waddr;
    logic [127:0] rd_data;
    logic [15:0]  rd_ecc;
    logic         reg_wr_en;
    logic [2:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic         out_valid;
    logic [127:0] out_data;
    logic [31:0]  test_out_hi, test_out_lo, err_status;
    logic         sbe_irq, nmi_req;

    always #4 clk = ~clk;

    flash_secded_check #(.CNT_W(TCNT)) dut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_waddr(rd_waddr),
        .rd_data(rd_data), .rd_ecc(rd_ecc), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .out_valid(out_valid),
        .out_data(out_data), .test_out_hi(test_out_hi), .test_out_lo(test_out_lo),
        .err_status(err_status), .sbe_irq(sbe_irq), .nmi_req(nmi_req)
    );

    typedef struct {
        string        tag;
        logic         ov;
        logic [127:0] od;
        logic [31:0]  st;
        logic         irq;
        logic         nmi;
        logic [63:0]  tout;
    } exp_t;

    typedef struct {
        logic [63:0] d;
        logic        sbe;
        logic        ue;
        logic [6:0]  pos;
    } bdec_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    logic [7:0] cols [83];

    // Bench model state
    bit          m_ten, m_sel;
    logic [63:0] m_td;
    logic [7:0]  m_tc;
    logic [18:0] m_ta;
    logic [3:0]  m_thr, m_cnt;
    bit          m_sf, m_uf, m_unit;
    logic [6:0]  m_pos;
    logic [63:0] m_tout;

    function automatic logic [7:0] enc(logic [63:0] d, logic [18:0] a);
        logic [7:0] c = '0;
        for (int i = 0; i < 64; i++) if (d[i]) c ^= cols[i];
        for (int k = 0; k < 19; k++) if (a[k]) c ^= cols[64+k];
        return c;
    endfunction

    function automatic bdec_t bdec(logic [63:0] d, logic [7:0] c, logic [18:0] a);
        bdec_t r;
        logic [7:0] s;
        r.d = d; r.sbe = 0; r.ue = 0; r.pos = 0;
        s = enc(d, a) ^ c;
        if (s == 0) return r;
        if ($countones(s) == 1) begin
            r.sbe = 1;
            for (int b = 0; b < 8; b++) if (s[b]) r.pos = 7'(64 + b);
            return r;
        end
        for (int i = 0; i < 64; i++) if (s == cols[i]) begin
            r.sbe = 1; r.pos = 7'(i); r.d[i] = ~d[i]; return r;
        end
        r.ue = 1;
        return r;
    endfunction

    function automatic logic [15:0] good_ecc(logic [127:0] d, logic [17:0] wa);
        return {enc(d[127:64], {wa, 1'b1}), enc(d[63:0], {wa, 1'b0})};
    endfunction

    function automatic logic [31:0] mstat();
        logic [31:0] s = '0;
        s[0] = m_sf; s[1] = m_uf; s[2] = m_unit; s[14:8] = m_pos; s[19:16] = m_cnt;
        return s;
    endfunction

    // One driven cycle: model it, drive it, queue the expected result.
    task automatic cyc(string tag, bit we, logic [2:0] wa, logic [31:0] wd,
                       bit rv, logic [127:0] rd, logic [15:0] re, logic [17:0] ra);
        exp_t  e;
        bdec_t lo, hi, t;
        bit    s0, s1, u0, u1, anys, anyu, clr0, clr1;
        logic [3:0] base;
        @(negedge clk);
        reg_wr_en = we; reg_addr = wa; reg_wdata = wd;
        rd_valid = rv; rd_data = rd; rd_ecc = re; rd_waddr = ra;
        s0 = 0; s1 = 0; u0 = 0; u1 = 0;
        lo = bdec(rd[63:0], re[7:0], {ra, 1'b0});
        hi = bdec(rd[127:64], re[15:8], {ra, 1'b1});
        t  = bdec(m_td, m_tc, m_ta);
        if (m_ten) begin
            if (m_sel) begin hi = t; s1 = t.sbe; u1 = t.ue; end
            else       begin lo = t; s0 = t.sbe; u0 = t.ue; end
        end else if (rv) begin
            s0 = lo.sbe; s1 = hi.sbe; u0 = lo.ue; u1 = hi.ue;
        end
        anys = s0 | s1; anyu = u0 | u1;
        clr0 = we && wa == 3'd6 && wd[0];
        clr1 = we && wa == 3'd6 && wd[1];
        base = clr1 ? 4'd0 : m_cnt;
        if (anys && base != 4'hF) base = base + 4'd1;
        m_cnt = base;
        e.irq = anys && (base > m_thr);
        e.nmi = anyu;
        m_sf = anys | (m_sf & !clr0);
        m_uf = anyu | (m_uf & !clr0);
        if (anys) begin
            m_unit = !s0; m_pos = s0 ? lo.pos : hi.pos;
        end else if (clr0) begin
            m_unit = 0; m_pos = 0;
        end
        e.ov = rv && !m_ten;
        e.od = {hi.d, lo.d};
        if (m_ten) m_tout = t.d;
        e.tout = m_tout;
        e.st = mstat();
        e.tag = tag;
        if (we) begin
            case (wa)
                3'd0: begin m_ten = wd[0]; m_sel = wd[1]; end
                3'd1: m_td[31:0]  = wd;
                3'd2: m_td[63:32] = wd;
                3'd3: m_tc = wd[7:0];
                3'd4: m_ta = wd[18:0];
                3'd5: m_thr = wd[3:0];
                default: ;
            endcase
        end
        @(posedge clk);
        q.push_back(e);
    endtask

    task automatic rd(string tag, logic [127:0] d, logic [15:0] c, logic [17:0] a);
        cyc(tag, 0, 3'd0, 32'd0, 1, d, c, a);
    endtask

    task automatic wr(string tag, logic [2:0] a, logic [31:0] d);
        cyc(tag, 1, a, d, 0, 128'd0, 16'd0, 18'd0);
    endtask

    // Monitor: compare each queued item after the edge it belongs to.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            bit   bad;
            e = q.pop_front();
            bad = 0;
            n_chk++;
            if (out_valid !== e.ov) begin bad = 1;
                $display("FAIL %s: out_valid act %0b exp %0b", e.tag, out_valid, e.ov); end
            if (e.ov && out_data !== e.od) begin bad = 1;
                $display("FAIL %s: out_data act %h exp %h", e.tag, out_data, e.od); end
            if (err_status !== e.st) begin bad = 1;
                $display("FAIL %s: status act %h exp %h", e.tag, err_status, e.st); end
            if (sbe_irq !== e.irq) begin bad = 1;
                $display("FAIL %s: sbe_irq act %0b exp %0b", e.tag, sbe_irq, e.irq); end
            if (nmi_req !== e.nmi) begin bad = 1;
                $display("FAIL %s: nmi act %0b exp %0b", e.tag, nmi_req, e.nmi); end
            if ({test_out_hi, test_out_lo} !== e.tout) begin bad = 1;
                $display("FAIL %s: test_out act %h exp %h", e.tag, {test_out_hi, test_out_lo}, e.tout); end
            if (bad) n_fail++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act running exp finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] D1, D2;
        logic [17:0]  A1;
        logic [15:0]  E1;
        logic [63:0]  TD;
        logic [18:0]  TA;
        int n = 0;
        for (int w = 3; w <= 5; w += 2)
            for (int v = 1; v < 256; v++)
                if ($countones(8'(v)) == w && n < 83) begin cols[n] = 8'(v); n++; end
        m_ten = 0; m_sel = 0; m_td = 0; m_tc = 0; m_ta = 0; m_thr = 0; m_cnt = 0;
        m_sf = 0; m_uf = 0; m_unit = 0; m_pos = 0; m_tout = 0;
        rst_n = 0; rd_valid = 0; rd_waddr = 0; rd_data = 0; rd_ecc = 0;
        reg_wr_en = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        n_chk++;
        if (out_valid !== 0 || err_status !== 0 || sbe_irq !== 0 || nmi_req !== 0 ||
            test_out_hi !== 0 || test_out_lo !== 0) begin
            n_fail++;
            $display("FAIL R11 reset: act %b %h %b %b %h %h exp all zero", out_valid, err_status,
                     sbe_irq, nmi_req, test_out_hi, test_out_lo);
        end
        rst_n = 1;

        D1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        D2 = 128'hA5A5_0F0F_3C3C_9696_0000_FFFF_1234_8001;
        A1 = 18'h2A5C3;
        E1 = good_ecc(D1, A1);
        rd("R1 clean read", D1, E1, A1);
        rd("R1 clean read 2", D2, good_ecc(D2, 18'h00011), 18'h00011);
        rd("R2 lower data bit 5", D1 ^ (128'd1 << 5), E1, A1);
        rd("R5 upper data bit 63", D1 ^ (128'd1 << 127), E1, A1);
        rd("R5 both halves lower wins", D1 ^ (128'd1 << 70) ^ (128'd1 << 9), E1, A1);
        rd("R3 lower check bit 3", D1, E1 ^ 16'h0008, A1);
        rd("R3 upper check bit 7", D1, E1 ^ 16'h8000, A1);
        rd("R4 double data error", D1 ^ (128'd1 << 10) ^ (128'd1 << 20), E1, A1);
        rd("R4 address mismatch", D1, E1, A1 ^ 18'h00002);
        cyc("R10 idle", 0, 3'd0, 32'd0, 0, D1, E1, A1);
        wr("R9 clear flags", 3'd6, 32'd1);
        rd("R9 clean after clear", D1, E1, A1);
        wr("R8 threshold 2", 3'd5, 32'd2);
        wr("R8 clear counter", 3'd6, 32'd2);
        rd("R8 threshold event 1", D1 ^ (128'd1 << 33), E1, A1);
        rd("R8 threshold event 2", D1 ^ (128'd1 << 34), E1, A1);
        rd("R8 threshold event 3", D1 ^ (128'd1 << 35), E1, A1);
        cyc("R9 clear with event", 1, 3'd6, 32'd3, 1, D1 ^ (128'd1 << 1), E1, A1);
        wr("R8 threshold 0", 3'd5, 32'd0);

        TD = 64'hDEAD_BEEF_0BAD_F00D;
        TA = 19'h5_1234;
        wr("R6 test data lo", 3'd1, TD[31:0] ^ 32'h0001_0000);
        wr("R6 test data hi", 3'd2, TD[63:32]);
        wr("R6 test check", 3'd3, {24'd0, enc(TD, TA)});
        wr("R6 test addr", 3'd4, {13'd0, TA});
        wr("R7 enable test lower", 3'd0, 32'd1);
        for (int i = 0; i < 20; i++)
            rd("R7 R8 test cycle saturating", D1 ^ (128'd1 << 3), E1, A1);
        wr("R7 select upper", 3'd0, 32'd3);
        wr("R7 double check error", 3'd3, {24'd0, enc(TD, TA) ^ 8'h03});
        for (int i = 0; i < 4; i++)
            rd("R7 repeated nmi", D1, E1, A1);
        wr("R7 test off", 3'd0, 32'd0);
        for (int i = 0; i < 2; i++)
            cyc("R7 pulses stop", 0, 3'd0, 32'd0, 0, D1, E1, A1);
        wr("R9 clear all", 3'd6, 32'd3);
        rd("R1 clean after test", D2, good_ecc(D2, A1), A1);
        cyc("R10 drain", 0, 3'd0, 32'd0, 0, 128'd0, 16'd0, 18'd0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule